// File: doc/BRIEF.md
# Video Core Control Register Bank and Frame Sequencer

This block is the control side of a streaming video processing engine. Software programs it through a plain register port (one-cycle write strobe, one-cycle read strobe, read data one clock later). The registers hold the run control word, the input and output colour format codes, the frame size, a 3x3 coefficient matrix, three per-channel offsets, and a lower clamp and upper clip bound for the arithmetic that sits downstream.

Once started, the block walks a frame position by position under a downstream ready signal. It presents the current pixel and line index, flags the first position of the frame, the last position of every line and the final position of the frame. At every frame start it copies the whole configuration into an active set that stays constant for the frame, so software may rewrite registers while a frame is in flight. A single start runs one frame; start together with the auto-restart bit runs frames back to back until the control word is cleared.

Top module: `vid_ctl_seq`

## Requirements
- R1: After synchronous reset the control word reads 0x0000000C (idle bit 2 and ready bit 3 set; start bit 0, done bit 1 and auto-restart bit 7 clear), both format registers read 2 (encoding 0 RGB, 1 YCbCr 4:4:4, 2 YCbCr 4:2:2, 3 YCbCr 4:2:0), coefficient K11 reads 4096, K12 reads 0, and out_valid is low.
- R2: Registers sit at byte offsets control 0x00, input format 0x10, output format 0x18, width 0x20, height 0x28, K11..K33 row-major at 0x50 + 8*i (i = 0..8), channel offsets at 0x98, 0xA0, 0xA8, clamp 0xB0, clip 0xB8; coefficients and offsets keep 16 bits and read back sign-extended, formats keep bits [1:0], clamp and clip read back zero-extended; any other offset reads 0 and ignores writes; read data appears on the clock after the read strobe.
- R3: A width write below 64 stores 64 and above 8192 stores 8192; a height write below 64 stores 64 and above 4320 stores 4320; values inside the range are stored as written.
- R4: Writing 0x01 to the control word starts exactly one frame of width*height accepted beats; start reads 0 once the frame has begun, and after the last beat the block is idle with done set (control word reads 0x0E).
- R5: With bit 0 and bit 7 both written (0x81) frames follow one another with no gap cycle (next frame's first beat directly after the previous last beat when ready stays high), until the control word is written 0; the frame then in flight completes and no further frame starts.
- R6: out_sof is high on the first beat of a frame only, out_eol on every beat with pix_x equal to active width minus one, out_last on the final beat of the frame only.
- R7: While out_valid is high and pix_ready low, the position and all flags hold; the position advances only on an accepted beat.
- R8: The act_* outputs change only at a frame start, taking the register values of that cycle; a register write during a frame leaves them and the frame geometry unchanged until the next frame. act_coef holds K11 in bits [15:0] up to K33 in bits [143:128].
- R9: Done is set on the cycle a frame ends and cleared by a read of the control word; when both happen in the same cycle, the read returns done as 0 and done stays set for the next read.
- R10: A synchronous reset in the middle of a frame drops out_valid and returns every register, including the active set, to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, valid the clock after reg_rd |
| pix_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A frame position is presented |
| out_sof | output | 1 | First beat of the frame |
| out_eol | output | 1 | Last beat of a line |
| out_last | output | 1 | Last beat of the frame |
| pix_x | output | XW (14) | Pixel index in the line |
| pix_y | output | YW (13) | Line index in the frame |
| act_in_fmt | output | 2 | Active input format code |
| act_out_fmt | output | 2 | Active output format code |
| act_width | output | XW (14) | Active frame width |
| act_height | output | YW (13) | Active frame height |
| act_coef | output | 9*CW (144) | Active coefficients, K11 in the low slice |
| act_off | output | 3*CW (48) | Active channel offsets, first channel low |
| act_clamp | output | CW (16) | Active clamp minimum |
| act_clip | output | CW (16) | Active clip maximum |

## Verification
The end of a frame, which sets done, and a software read of the control word, which clears it, can land in one clock. The bench provokes this by holding the read strobe on the control word for every cycle across the end of a frame and collecting the returned words: exactly one of them must show done, which proves the set was neither lost to the clear nor repeated. A second coincidence, the last beat of a frame meeting a still-set start bit, is judged by the cycle distance between consecutive frame-start beats under auto-restart.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [1:0] {
    FMT_RGB = 2'd0,
    FMT_444 = 2'd1,
    FMT_422 = 2'd2,
    FMT_420 = 2'd3
  } fmt_e;

  localparam int A_CTRL   = 'h00;
  localparam int A_INFMT  = 'h10;
  localparam int A_OUTFMT = 'h18;
  localparam int A_WIDTH  = 'h20;
  localparam int A_HEIGHT = 'h28;
  localparam int A_COEF0  = 'h50;
  localparam int A_OFF0   = 'h98;
  localparam int A_CLAMP  = 'hB0;
  localparam int A_CLIP   = 'hB8;
  localparam int A_STEP   = 8;

  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_IDLE  = 2;
  localparam int B_READY = 3;
  localparam int B_AUTO  = 7;

endpackage

// File: rtl/vcs_seq.sv
module vcs_seq #(
  parameter int XW = 14,
  parameter int YW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_q,
  input  logic          pix_ready,
  input  logic [XW-1:0] width,
  input  logic [YW-1:0] height,
  output logic          frm_begin,
  output logic          frm_end,
  output logic          run,
  output logic          sof,
  output logic          eol,
  output logic          last,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);

  logic          run_q, sof_q, eol_q, last_q;
  logic [XW-1:0] x_q, x_nxt;
  logic [YW-1:0] y_q;
  logic          advance, at_eol;

  assign advance   = run_q & pix_ready;
  assign frm_end   = advance & last_q;
  assign frm_begin = start_q & (~run_q | frm_end);
  assign x_nxt     = x_q + 1'b1;
  assign at_eol    = (x_nxt == width - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sof_q  <= 1'b0;
      eol_q  <= 1'b0;
      last_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (frm_begin) begin
      run_q  <= 1'b1;
      sof_q  <= 1'b1;
      eol_q  <= 1'b0;
      last_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (frm_end) begin
      run_q  <= 1'b0;
      sof_q  <= 1'b0;
      eol_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (advance) begin
      sof_q <= 1'b0;
      if (eol_q) begin
        x_q    <= '0;
        y_q    <= y_q + 1'b1;
        eol_q  <= 1'b0;
        last_q <= 1'b0;
      end else begin
        x_q    <= x_nxt;
        eol_q  <= at_eol;
        last_q <= at_eol & (y_q == height - 1'b1);
      end
    end
  end

  assign run  = run_q;
  assign sof  = sof_q;
  assign eol  = eol_q;
  assign last = last_q;
  assign x    = x_q;
  assign y    = y_q;

endmodule

// File: rtl/vcs_regs.sv
module vcs_regs
  import vcs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int NCOEF = 9,
  parameter int NOFF  = 3,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192,
  parameter int MIN_H = 64,
  parameter int MAX_H = 4320,
  parameter int UNITY = 4096,
  parameter int DEPTH = 8,
  parameter int XW    = 14,
  parameter int YW    = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic                  frm_begin,
  input  logic                  frm_end,
  input  logic                  run,
  output logic                  start_q,
  output logic [1:0]            in_fmt,
  output logic [1:0]            out_fmt,
  output logic [XW-1:0]         width,
  output logic [YW-1:0]         height,
  output logic [NCOEF*CW-1:0]   coef,
  output logic [NOFF*CW-1:0]    off,
  output logic [CW-1:0]         clamp,
  output logic [CW-1:0]         clip
);

  logic          auto_q, done_q;
  logic [1:0]    in_fmt_q, out_fmt_q;
  logic [XW-1:0] width_q;
  logic [YW-1:0] height_q;
  logic [CW-1:0] coef_q [NCOEF];
  logic [CW-1:0] off_q  [NOFF];
  logic [CW-1:0] clamp_q, clip_q;
  logic [DW-1:0] rd_mux;
  logic          ctl_hit;

  assign ctl_hit = (addr == AW'(A_CTRL));

  function automatic logic [XW-1:0] sat_w(input logic [DW-1:0] v);
    if (v < DW'(MIN_W))      return XW'(MIN_W);
    else if (v > DW'(MAX_W)) return XW'(MAX_W);
    else                     return v[XW-1:0];
  endfunction

  function automatic logic [YW-1:0] sat_h(input logic [DW-1:0] v);
    if (v < DW'(MIN_H))      return YW'(MIN_H);
    else if (v > DW'(MAX_H)) return YW'(MAX_H);
    else                     return v[YW-1:0];
  endfunction

  // run control and status
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr && ctl_hit) begin
        start_q <= wdata[B_START];
        auto_q  <= wdata[B_AUTO];
      end else if (frm_begin && !auto_q) begin
        start_q <= 1'b0;
      end
      if (frm_end)            done_q <= 1'b1;
      else if (rd && ctl_hit) done_q <= 1'b0;
    end
  end

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      in_fmt_q  <= FMT_422;
      out_fmt_q <= FMT_422;
      width_q   <= XW'(MIN_W);
      height_q  <= YW'(MIN_H);
      clamp_q   <= '0;
      clip_q    <= CW'((1 << DEPTH) - 1);
      for (int i = 0; i < NCOEF; i++)
        coef_q[i] <= (i % 4 == 0) ? CW'(UNITY) : '0;
      for (int c = 0; c < NOFF; c++)
        off_q[c] <= '0;
    end else if (wr) begin
      if (addr == AW'(A_INFMT))  in_fmt_q  <= wdata[1:0];
      if (addr == AW'(A_OUTFMT)) out_fmt_q <= wdata[1:0];
      if (addr == AW'(A_WIDTH))  width_q   <= sat_w(wdata);
      if (addr == AW'(A_HEIGHT)) height_q  <= sat_h(wdata);
      if (addr == AW'(A_CLAMP))  clamp_q   <= wdata[CW-1:0];
      if (addr == AW'(A_CLIP))   clip_q    <= wdata[CW-1:0];
      for (int i = 0; i < NCOEF; i++)
        if (addr == AW'(A_COEF0 + A_STEP * i)) coef_q[i] <= wdata[CW-1:0];
      for (int c = 0; c < NOFF; c++)
        if (addr == AW'(A_OFF0 + A_STEP * c)) off_q[c] <= wdata[CW-1:0];
    end
  end

  // read decode
  always_comb begin
    rd_mux = '0;
    if (ctl_hit) begin
      rd_mux[B_START] = start_q;
      rd_mux[B_DONE]  = done_q;
      rd_mux[B_IDLE]  = ~run;
      rd_mux[B_READY] = ~run & ~start_q;
      rd_mux[B_AUTO]  = auto_q;
    end
    if (addr == AW'(A_INFMT))  rd_mux = DW'(in_fmt_q);
    if (addr == AW'(A_OUTFMT)) rd_mux = DW'(out_fmt_q);
    if (addr == AW'(A_WIDTH))  rd_mux = DW'(width_q);
    if (addr == AW'(A_HEIGHT)) rd_mux = DW'(height_q);
    if (addr == AW'(A_CLAMP))  rd_mux = DW'(clamp_q);
    if (addr == AW'(A_CLIP))   rd_mux = DW'(clip_q);
    for (int i = 0; i < NCOEF; i++)
      if (addr == AW'(A_COEF0 + A_STEP * i))
        rd_mux = {{(DW-CW){coef_q[i][CW-1]}}, coef_q[i]};
    for (int c = 0; c < NOFF; c++)
      if (addr == AW'(A_OFF0 + A_STEP * c))
        rd_mux = {{(DW-CW){off_q[c][CW-1]}}, off_q[c]};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  generate
    for (genvar g = 0; g < NCOEF; g++) begin : g_coef
      assign coef[g*CW +: CW] = coef_q[g];
    end
    for (genvar g = 0; g < NOFF; g++) begin : g_off
      assign off[g*CW +: CW] = off_q[g];
    end
  endgenerate

  assign in_fmt  = in_fmt_q;
  assign out_fmt = out_fmt_q;
  assign width   = width_q;
  assign height  = height_q;
  assign clamp   = clamp_q;
  assign clip    = clip_q;

endmodule

// File: rtl/vcs_shadow.sv
module vcs_shadow
  import vcs_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NCOEF = 9,
  parameter int NOFF  = 3,
  parameter int MIN_W = 64,
  parameter int MIN_H = 64,
  parameter int UNITY = 4096,
  parameter int DEPTH = 8,
  parameter int XW    = 14,
  parameter int YW    = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [1:0]          in_fmt,
  input  logic [1:0]          out_fmt,
  input  logic [XW-1:0]       width,
  input  logic [YW-1:0]       height,
  input  logic [NCOEF*CW-1:0] coef,
  input  logic [NOFF*CW-1:0]  off,
  input  logic [CW-1:0]       clamp,
  input  logic [CW-1:0]       clip,
  output logic [1:0]          a_in_fmt,
  output logic [1:0]          a_out_fmt,
  output logic [XW-1:0]       a_width,
  output logic [YW-1:0]       a_height,
  output logic [NCOEF*CW-1:0] a_coef,
  output logic [NOFF*CW-1:0]  a_off,
  output logic [CW-1:0]       a_clamp,
  output logic [CW-1:0]       a_clip
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_in_fmt  <= FMT_422;
      a_out_fmt <= FMT_422;
      a_width   <= XW'(MIN_W);
      a_height  <= YW'(MIN_H);
      a_off     <= '0;
      a_clamp   <= '0;
      a_clip    <= CW'((1 << DEPTH) - 1);
      for (int i = 0; i < NCOEF; i++)
        a_coef[i*CW +: CW] <= (i % 4 == 0) ? CW'(UNITY) : '0;
    end else if (load) begin
      a_in_fmt  <= in_fmt;
      a_out_fmt <= out_fmt;
      a_width   <= width;
      a_height  <= height;
      a_coef    <= coef;
      a_off     <= off;
      a_clamp   <= clamp;
      a_clip    <= clip;
    end
  end

endmodule

// File: rtl/vid_ctl_seq.sv
module vid_ctl_seq #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int NCOEF = 9,
  parameter int NOFF  = 3,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192,
  parameter int MIN_H = 64,
  parameter int MAX_H = 4320,
  parameter int UNITY = 4096,
  parameter int DEPTH = 8,
  localparam int XW   = $clog2(MAX_W + 1),
  localparam int YW   = $clog2(MAX_H + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                pix_ready,
  output logic                out_valid,
  output logic                out_sof,
  output logic                out_eol,
  output logic                out_last,
  output logic [XW-1:0]       pix_x,
  output logic [YW-1:0]       pix_y,
  output logic [1:0]          act_in_fmt,
  output logic [1:0]          act_out_fmt,
  output logic [XW-1:0]       act_width,
  output logic [YW-1:0]       act_height,
  output logic [NCOEF*CW-1:0] act_coef,
  output logic [NOFF*CW-1:0]  act_off,
  output logic [CW-1:0]       act_clamp,
  output logic [CW-1:0]       act_clip
);

  logic                ctl_start, frm_begin, frm_end, seq_run;
  logic [1:0]          cfg_in_fmt, cfg_out_fmt;
  logic [XW-1:0]       cfg_width;
  logic [YW-1:0]       cfg_height;
  logic [NCOEF*CW-1:0] cfg_coef;
  logic [NOFF*CW-1:0]  cfg_off;
  logic [CW-1:0]       cfg_clamp, cfg_clip;

  vcs_regs #(
    .AW(AW), .DW(DW), .CW(CW), .NCOEF(NCOEF), .NOFF(NOFF),
    .MIN_W(MIN_W), .MAX_W(MAX_W), .MIN_H(MIN_H), .MAX_H(MAX_H),
    .UNITY(UNITY), .DEPTH(DEPTH), .XW(XW), .YW(YW)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .frm_begin(frm_begin), .frm_end(frm_end), .run(seq_run),
    .start_q(ctl_start),
    .in_fmt(cfg_in_fmt), .out_fmt(cfg_out_fmt),
    .width(cfg_width), .height(cfg_height),
    .coef(cfg_coef), .off(cfg_off), .clamp(cfg_clamp), .clip(cfg_clip)
  );

  vcs_shadow #(
    .CW(CW), .NCOEF(NCOEF), .NOFF(NOFF), .MIN_W(MIN_W), .MIN_H(MIN_H),
    .UNITY(UNITY), .DEPTH(DEPTH), .XW(XW), .YW(YW)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(frm_begin),
    .in_fmt(cfg_in_fmt), .out_fmt(cfg_out_fmt),
    .width(cfg_width), .height(cfg_height),
    .coef(cfg_coef), .off(cfg_off), .clamp(cfg_clamp), .clip(cfg_clip),
    .a_in_fmt(act_in_fmt), .a_out_fmt(act_out_fmt),
    .a_width(act_width), .a_height(act_height),
    .a_coef(act_coef), .a_off(act_off),
    .a_clamp(act_clamp), .a_clip(act_clip)
  );

  vcs_seq #(.XW(XW), .YW(YW)) u_seq (
    .clk(clk), .rst(rst), .start_q(ctl_start), .pix_ready(pix_ready),
    .width(act_width), .height(act_height),
    .frm_begin(frm_begin), .frm_end(frm_end), .run(seq_run),
    .sof(out_sof), .eol(out_eol), .last(out_last),
    .x(pix_x), .y(pix_y)
  );

  assign out_valid = seq_run;

endmodule

// File: rtl/vcs_chk.sv
module vcs_chk #(
  parameter int XW    = 14,
  parameter int YW    = 13,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_ready,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eol,
  input logic          out_last,
  input logic          ctl_start,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic [XW-1:0] act_width
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !pix_ready |=> out_valid && $stable(pix_x) && $stable(pix_y)
      && $stable(out_sof) && $stable(out_eol) && $stable(out_last));

  // R6
  eol_pos_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eol |-> pix_x == act_width - 1'b1);

  // R6
  last_on_eol_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_eol);

  // R6
  sof_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> pix_x == '0 && pix_y == '0 && !out_eol);

  // R4
  single_stop_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && pix_ready && !ctl_start |=> !out_valid);

  // R5
  chain_nogap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && pix_ready && ctl_start |=> out_valid && out_sof);

  // R3
  width_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_width >= XW'(MIN_W) && act_width <= XW'(MAX_W));

endmodule

bind vid_ctl_seq vcs_chk #(
  .XW(XW), .YW(YW), .MIN_W(MIN_W), .MAX_W(MAX_W)
) u_chk (
  .clk(clk), .rst(rst), .pix_ready(pix_ready), .out_valid(out_valid),
  .out_sof(out_sof), .out_eol(out_eol), .out_last(out_last),
  .ctl_start(ctl_start), .pix_x(pix_x), .pix_y(pix_y), .act_width(act_width)
);

// File: tb/test_vid_ctl_seq.sv
module test_vid_ctl_seq;

  localparam int XW = 14;
  localparam int YW = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         pix_ready = 1'b1;
  logic         out_valid, out_sof, out_eol, out_last;
  logic [XW-1:0] pix_x, act_width;
  logic [YW-1:0] pix_y, act_height;
  logic [1:0]   act_in_fmt, act_out_fmt;
  logic [143:0] act_coef;
  logic [47:0]  act_off;
  logic [15:0]  act_clamp, act_clip;

  vid_ctl_seq i_vid_ctl_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_ready(pix_ready), .out_valid(out_valid), .out_sof(out_sof),
    .out_eol(out_eol), .out_last(out_last), .pix_x(pix_x), .pix_y(pix_y),
    .act_in_fmt(act_in_fmt), .act_out_fmt(act_out_fmt),
    .act_width(act_width), .act_height(act_height),
    .act_coef(act_coef), .act_off(act_off),
    .act_clamp(act_clamp), .act_clip(act_clip)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int sof_cnt = 0;
  int sof_cyc[$];
  bit rdy_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct packed { logic sof; logic eol; logic last; } beat_t;
  beat_t exp_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  // ready generator
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = rdy_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && pix_ready) begin
      if (out_sof) begin
        sof_cnt++;
        sof_cyc.push_back(cyc);
      end
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 R5 beat with nothing expected", {out_sof, out_eol, out_last}, 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check({out_sof, out_eol, out_last} == e, "R6 R7 beat flags",
              {out_sof, out_eol, out_last}, e);
      end
    end
  end

  task automatic push_frame(input int w, input int h);
    for (int yy = 0; yy < h; yy++)
      for (int xx = 0; xx < w; xx++) begin
        beat_t b;
        b.sof  = (xx == 0 && yy == 0);
        b.eol  = (xx == w - 1);
        b.last = (xx == w - 1 && yy == h - 1);
        exp_q.push_back(b);
      end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_drained();
    wait (exp_q.size() == 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 idle after frame", out_valid, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int ones;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(act_in_fmt == 2'd2, "R1 act_in_fmt", act_in_fmt, 2);
    rd_reg(8'h00, v); check(v == 32'h0C, "R1 ctrl", v, 32'h0C);
    rd_reg(8'h10, v); check(v == 32'd2, "R1 in fmt", v, 2);
    rd_reg(8'h18, v); check(v == 32'd2, "R1 out fmt", v, 2);
    rd_reg(8'h50, v); check(v == 32'd4096, "R1 K11", v, 4096);
    rd_reg(8'h58, v); check(v == 32'd0, "R1 K12", v, 0);

    // R2 register map
    wr_reg(8'h10, 32'd1);
    wr_reg(8'h18, 32'd0);
    for (int i = 0; i < 9; i++) wr_reg(8'(8'h50 + 8 * i), 32'(i * 700 - 2800));
    for (int c = 0; c < 3; c++) wr_reg(8'(8'h98 + 8 * c), 32'(-100 * (c + 1)));
    wr_reg(8'hB0, 32'd16);
    wr_reg(8'hB8, 32'd235);
    wr_reg(8'h40, 32'hDEADBEEF);
    rd_reg(8'h10, v); check(v == 32'd1, "R2 in fmt", v, 1);
    rd_reg(8'h18, v); check(v == 32'd0, "R2 out fmt", v, 0);
    for (int i = 0; i < 9; i++) begin
      rd_reg(8'(8'h50 + 8 * i), v);
      check(v == 32'(i * 700 - 2800), "R2 coefficient", v, 32'(i * 700 - 2800));
    end
    for (int c = 0; c < 3; c++) begin
      rd_reg(8'(8'h98 + 8 * c), v);
      check(v == 32'(-100 * (c + 1)), "R2 offset", v, 32'(-100 * (c + 1)));
    end
    rd_reg(8'hB0, v); check(v == 32'd16, "R2 clamp", v, 16);
    rd_reg(8'hB8, v); check(v == 32'd235, "R2 clip", v, 235);
    rd_reg(8'h40, v); check(v == 32'd0, "R2 unmapped", v, 0);

    // R3 saturation
    wr_reg(8'h20, 32'd10);   rd_reg(8'h20, v); check(v == 32'd64, "R3 width low", v, 64);
    wr_reg(8'h20, 32'd9000); rd_reg(8'h20, v); check(v == 32'd8192, "R3 width high", v, 8192);
    wr_reg(8'h28, 32'd5000); rd_reg(8'h28, v); check(v == 32'd4320, "R3 height high", v, 4320);
    wr_reg(8'h28, 32'd3);    rd_reg(8'h28, v); check(v == 32'd64, "R3 height low", v, 64);
    wr_reg(8'h28, 32'd70);   rd_reg(8'h28, v); check(v == 32'd70, "R3 height mid", v, 70);
    wr_reg(8'h20, 32'd64);
    wr_reg(8'h28, 32'd64);

    // R4 single frame with stalls, R8 shadowing
    rdy_mode = 1'b1;
    push_frame(64, 64);
    wr_reg(8'h00, 32'h01);
    wait (sof_cnt == 1);
    check(act_in_fmt == 2'd1, "R8 act in fmt", act_in_fmt, 1);
    check(act_coef[15:0] == 16'(-2800), "R8 act K11", act_coef[15:0], 16'(-2800));
    check(act_clip == 16'd235, "R8 act clip", act_clip, 235);
    rd_reg(8'h00, v); check(v == 32'h00, "R4 start self clear", v, 0);
    wr_reg(8'h20, 32'd96);
    wr_reg(8'h50, 32'h0777);
    @(negedge clk);
    check(act_width == 14'd64, "R8 width held mid frame", act_width, 64);
    check(act_coef[15:0] == 16'(-2800), "R8 K11 held mid frame", act_coef[15:0], 16'(-2800));
    wait_drained();
    rd_reg(8'h00, v); check(v == 32'h0E, "R4 done idle", v, 32'h0E);
    rd_reg(8'h00, v); check(v == 32'h0C, "R9 done cleared", v, 32'h0C);

    // R8 next frame picks up new size
    push_frame(96, 64);
    wr_reg(8'h00, 32'h01);
    wait (sof_cnt == 2);
    check(act_width == 14'd96, "R8 new width", act_width, 96);
    check(act_coef[15:0] == 16'h0777, "R8 new K11", act_coef[15:0], 16'h0777);
    wait_drained();
    rd_reg(8'h00, v); check(v == 32'h0E, "R4 second frame done", v, 32'h0E);

    // R5 auto restart, ready held high
    rdy_mode = 1'b0;
    wr_reg(8'h20, 32'd64);
    push_frame(64, 64); push_frame(64, 64); push_frame(64, 64);
    wr_reg(8'h00, 32'h81);
    wait (sof_cnt == 5);
    rd_reg(8'h00, v); check((v & 32'h8D) == 32'h81, "R5 running state", v & 32'h8D, 32'h81);
    wr_reg(8'h00, 32'h00);
    wait_drained();
    repeat (20) @(posedge clk);
    check(sof_cnt == 5, "R5 no frame after stop", sof_cnt, 5);
    check(sof_cyc[3] - sof_cyc[2] == 4096, "R5 gap 1", sof_cyc[3] - sof_cyc[2], 4096);
    check(sof_cyc[4] - sof_cyc[3] == 4096, "R5 gap 2", sof_cyc[4] - sof_cyc[3], 4096);
    rd_reg(8'h00, v); check(v == 32'h0E, "R5 idle after stop", v, 32'h0E);

    // R9 done set colliding with clear-on-read
    push_frame(64, 64);
    wr_reg(8'h00, 32'h01);
    wait (sof_cnt == 6);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = 8'h00;
    ones = 0;
    for (int k = 0; k < 4200; k++) begin
      @(posedge clk); #1;
      if (reg_rdata[1]) ones++;
    end
    check(reg_rdata[2] == 1'b1, "R9 idle seen", reg_rdata[2], 1);
    reg_rd = 1'b0;
    check(ones == 1, "R9 done seen once", ones, 1);
    check(exp_q.size() == 0, "R9 frame complete", exp_q.size(), 0);

    // R10 reset mid frame
    push_frame(64, 64);
    wr_reg(8'h00, 32'h01);
    wait (sof_cnt == 7);
    repeat (100) @(posedge clk);
    #1 rst = 1'b1;
    exp_q.delete();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid dropped", out_valid, 0);
    check(act_in_fmt == 2'd2, "R10 active fmt default", act_in_fmt, 2);
    check(act_coef[15:0] == 16'd4096, "R10 active K11 default", act_coef[15:0], 4096);
    rd_reg(8'h00, v); check(v == 32'h0C, "R10 ctrl", v, 32'h0C);
    rd_reg(8'h10, v); check(v == 32'd2, "R10 in fmt", v, 2);
    rd_reg(8'h50, v); check(v == 32'd4096, "R10 K11", v, 4096);
    repeat (10) @(posedge clk);
    check(sof_cnt == 7, "R10 no restart", sof_cnt, 7);

    finish_up();
  end

endmodule